// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Bank Close

This block decides when a memory controller owes the DRAM a refresh, and it runs the command sequence that delivers it. A free-running interval timer adds one refresh to a small debt counter every refresh slot. The slot is the retention window divided by the number of rows, converted to clock cycles at the operating frequency. While refreshes are owed and the block is not already working, it raises a request to the command arbiter.

When the arbiter grants, the block raises a busy flag that holds off normal traffic. If any bank is open, the block waits until the youngest activated row has been open for the minimum row-active time. It then issues one precharge-all and waits the precharge time before the auto-refresh. If every bank is already closed, it goes straight to the auto-refresh. No row address is supplied, because the device steps through its rows with its own counter.

After each auto-refresh the block waits the refresh-cycle time. All refreshes still owed at that point are issued back to back in the same busy period. The debt counter saturates, and a sticky flag records a refresh slot that was lost because the counter was full.

Top module: `refresh_scheduler`

## Requirements
- R1: During and directly after reset: owedCount is 0, refReq, busy, preAllStb, autoRefStb and owedOverflow are all 0.
- R2: The slot length is SLOT = RETENTION_US*CLK_MHZ/ROW_COUNT cycles. owedCount rises by one at the clock edge number n*SLOT after reset (edges counted from 1). refReq is 1 exactly when owedCount is nonzero and busy is 0.
- R3: With the arbiter granting every request at once, ROW_COUNT auto-refresh strobes fall in every window of ROW_COUNT*SLOT cycles that starts at a slot edge.
- R4: A grant while owedCount is 0 is ignored: busy stays 0 and no strobe is issued.
- R5: A grant sampled at edge g while every bankOpen bit is 0 gives autoRefStb in cycle g, with no preAllStb.
- R6: A grant sampled at edge g while any bankOpen bit is 1 gives preAllStb in cycle max(g+1, a+T_RAS). Here a is the latest edge that sampled actValid for any bank (actBank is a binary bank index).
- R7: autoRefStb follows preAllStb by exactly T_RP cycles, and the two strobes are never high together.
- R8: Every bank is closed whenever autoRefStb is high.
- R9: busy is 1 from cycle g until T_RAS, T_RP and the refresh sequence complete. Back-to-back autoRefStb pulses are exactly T_RFC cycles apart, and busy falls exactly T_RFC cycles after the last one.
- R10: owedCount never exceeds OWED_MAX. A slot that arrives when owedCount equals OWED_MAX, with no refresh in that cycle, sets owedOverflow, which then stays 1 until reset.
- R11: Each autoRefStb lowers owedCount by one. All refreshes owed when the sequence reaches its decision point are issued in the same busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bankOpen | input | NUM_BANKS | One bit per bank, 1 while a row is open |
| actValid | input | 1 | A row-activate command is issued this cycle |
| actBank | input | BANK_W | Binary index of the bank being activated |
| grant | input | 1 | Arbiter grant for the refresh request |
| refReq | output | 1 | Refresh owed and not yet being served |
| preAllStb | output | 1 | One-cycle precharge-all command strobe |
| autoRefStb | output | 1 | One-cycle auto-refresh command strobe |
| busy | output | 1 | Refresh sequence in progress, blocks normal traffic |
| owedCount | output | OWED_W | Number of refreshes currently owed |
| owedOverflow | output | 1 | Sticky: a refresh slot was lost to saturation |

## Verification
All timing follows from the sampling edge of each stimulus. The debt count and request move one cycle after a slot edge. With closed banks, the auto-refresh strobe appears in the cycle after the grant edge. Otherwise the precharge-all lands at the later of one cycle after the grant and T_RAS after the youngest activate. The auto-refresh then follows T_RP later, each further refresh T_RFC later, and busy drops T_RFC after the last. The bench counts clock edges since reset and samples on the falling edge. It compares the recorded edge of every strobe and of the busy fall against these offsets, computed from the parameters. A monitor checks the gap rules and the all-closed condition on every strobe, not only on the directed cases.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RAS_WAIT,
    ST_PRE,
    ST_RP_WAIT,
    ST_REF,
    ST_RFC_WAIT
  } schedState_t;

  // Strobes from the sequencer to the counters
  typedef struct packed {
    logic refIssue;  // one refresh leaves the debt counter
    logic loadRp;    // start the precharge gap
    logic loadRfc;   // start the refresh-cycle gap
    logic gapRun;    // let the gap counter count down
  } ctlStrobes_t;

endpackage

// File: rtl/refsched_datapath.sv
module refsched_datapath
  import refsched_pkg::*;
#(
  parameter int NUM_BANKS    = 4,
  parameter int REF_INTERVAL = 781,
  parameter int T_RAS        = 5,
  parameter int T_RP         = 2,
  parameter int T_RFC        = 12,
  parameter int OWED_MAX     = 8,
  localparam int BANK_W      = $clog2(NUM_BANKS),
  localparam int OWED_W      = $clog2(OWED_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              actValid,
  input  logic [BANK_W-1:0] actBank,
  input  ctlStrobes_t       ctl,
  output logic [OWED_W-1:0] owedCount,
  output logic              owedNonZero,
  output logic              owedOverflow,
  output logic              rasDone,
  output logic              gapDone
);

  localparam int IV_W    = $clog2(REF_INTERVAL);
  localparam int RAS_W   = $clog2(T_RAS + 1);
  localparam int GAP_MAX = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int GAP_W   = $clog2(GAP_MAX + 1);

  localparam logic [IV_W-1:0]   IV_LAST  = IV_W'(REF_INTERVAL - 1);
  localparam logic [RAS_W-1:0]  RAS_LOAD = RAS_W'(T_RAS - 1);
  localparam logic [GAP_W-1:0]  RP_LOAD  = GAP_W'(T_RP - 2);
  localparam logic [GAP_W-1:0]  RFC_LOAD = GAP_W'(T_RFC - 2);
  localparam logic [OWED_W-1:0] OWED_TOP = OWED_W'(OWED_MAX);

  // ---------------- refresh slot timer ----------------
  logic [IV_W-1:0] ivCnt;
  logic            slotTick;

  assign slotTick = (ivCnt == IV_LAST);

  always_ff @(posedge clk) begin
    if (!rstN)         ivCnt <= '0;
    else if (slotTick) ivCnt <= '0;
    else               ivCnt <= ivCnt + 1'b1;
  end

  // ---------------- owed-refresh counter ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      owedCount    <= '0;
      owedOverflow <= 1'b0;
    end else begin
      unique case ({slotTick, ctl.refIssue})
        2'b10: begin
          if (owedCount == OWED_TOP) owedOverflow <= 1'b1;
          else                       owedCount    <= owedCount + 1'b1;
        end
        2'b01:   owedCount <= owedCount - 1'b1;
        default: owedCount <= owedCount;
      endcase
    end
  end

  assign owedNonZero = (owedCount != '0);

  // ---------------- per-bank row-active timers ----------------
  logic [NUM_BANKS-1:0] rasZero;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [RAS_W-1:0] rasCnt;
    always_ff @(posedge clk) begin
      if (!rstN)                                  rasCnt <= '0;
      else if (actValid && actBank == BANK_W'(b)) rasCnt <= RAS_LOAD;
      else if (rasCnt != '0)                      rasCnt <= rasCnt - 1'b1;
    end
    assign rasZero[b] = (rasCnt == '0);
  end

  assign rasDone = &rasZero;

  // ---------------- shared gap counter (tRP / tRFC) ----------------
  logic [GAP_W-1:0] gapCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                          gapCnt <= '0;
    else if (ctl.loadRp)                gapCnt <= RP_LOAD;
    else if (ctl.loadRfc)               gapCnt <= RFC_LOAD;
    else if (ctl.gapRun && !gapDone)    gapCnt <= gapCnt - 1'b1;
  end

  assign gapDone = (gapCnt == '0);

  // ---------------- assertions ----------------
  assert_owed_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    owedCount <= OWED_TOP);

  assert_overflow_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    owedOverflow |=> owedOverflow);

  // R11: a refresh is only issued against a nonzero debt
  assert_issue_owed_R11: assert property (@(posedge clk) disable iff (!rstN)
    ctl.refIssue |-> owedCount != '0);

  // R10: a full counter stays full across a slot unless a refresh leaves it
  assert_saturate_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (slotTick && owedCount == OWED_TOP && !ctl.refIssue) |=> owedCount == OWED_TOP);

endmodule

// File: rtl/refsched_control.sv
module refsched_control
  import refsched_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        grant,
  input  logic        anyOpen,
  input  logic        owedNonZero,
  input  logic        rasDone,
  input  logic        gapDone,
  output ctlStrobes_t ctl,
  output logic        preAllStb,
  output logic        autoRefStb,
  output logic        busy
);

  schedState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:     if (grant && owedNonZero) nextState = anyOpen ? ST_RAS_WAIT : ST_REF;
      ST_RAS_WAIT: if (rasDone) nextState = ST_PRE;
      ST_PRE:      nextState = ST_RP_WAIT;
      ST_RP_WAIT:  if (gapDone) nextState = ST_REF;
      ST_REF:      nextState = ST_RFC_WAIT;
      ST_RFC_WAIT: if (gapDone) nextState = owedNonZero ? ST_REF : ST_IDLE;
      default:     nextState = ST_IDLE;
    endcase
  end

  assign preAllStb  = (state == ST_PRE);
  assign autoRefStb = (state == ST_REF);
  assign busy       = (state != ST_IDLE);

  always_comb begin
    ctl.refIssue = (state == ST_REF);
    ctl.loadRp   = (state == ST_PRE);
    ctl.loadRfc  = (state == ST_REF);
    ctl.gapRun   = (state == ST_RP_WAIT) || (state == ST_RFC_WAIT);
  end

  // ---------------- assertions ----------------
  assert_pre_after_ras_R6: assert property (@(posedge clk) disable iff (!rstN)
    preAllStb |-> rasDone);

  assert_busy_after_ref_R9: assert property (@(posedge clk) disable iff (!rstN)
    autoRefStb |=> busy);

  assert_grant_ignored_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !owedNonZero) |=> !busy);

  // R7: the refresh never directly follows the precharge-all
  assert_rp_gap_R7: assert property (@(posedge clk) disable iff (!rstN)
    preAllStb |=> !autoRefStb);

endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler
  import refsched_pkg::*;
#(
  parameter int NUM_BANKS    = 4,
  parameter int RETENTION_US = 64000,
  parameter int ROW_COUNT    = 8192,
  parameter int CLK_MHZ      = 100,
  parameter int T_RAS        = 5,
  parameter int T_RP         = 2,
  parameter int T_RFC        = 12,
  parameter int OWED_MAX     = 8,
  localparam int BANK_W      = $clog2(NUM_BANKS),
  localparam int OWED_W      = $clog2(OWED_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  logic                 actValid,
  input  logic [BANK_W-1:0]    actBank,
  input  logic                 grant,
  output logic                 refReq,
  output logic                 preAllStb,
  output logic                 autoRefStb,
  output logic                 busy,
  output logic [OWED_W-1:0]    owedCount,
  output logic                 owedOverflow
);

  localparam int REF_INTERVAL = RETENTION_US * CLK_MHZ / ROW_COUNT;

  if (REF_INTERVAL < 2 || T_RP < 2 || T_RFC < 2 || T_RAS < 1 || NUM_BANKS < 2) begin : g_badCfg
    $error("refresh_scheduler: timing parameters out of range");
  end

  ctlStrobes_t ctl;
  logic owedNonZero, rasDone, gapDone;

  refsched_datapath #(
    .NUM_BANKS   (NUM_BANKS),
    .REF_INTERVAL(REF_INTERVAL),
    .T_RAS       (T_RAS),
    .T_RP        (T_RP),
    .T_RFC       (T_RFC),
    .OWED_MAX    (OWED_MAX)
  ) uDatapath (
    .clk         (clk),
    .rstN        (rstN),
    .actValid    (actValid),
    .actBank     (actBank),
    .ctl         (ctl),
    .owedCount   (owedCount),
    .owedNonZero (owedNonZero),
    .owedOverflow(owedOverflow),
    .rasDone     (rasDone),
    .gapDone     (gapDone)
  );

  refsched_control uControl (
    .clk        (clk),
    .rstN       (rstN),
    .grant      (grant),
    .anyOpen    (|bankOpen),
    .owedNonZero(owedNonZero),
    .rasDone    (rasDone),
    .gapDone    (gapDone),
    .ctl        (ctl),
    .preAllStb  (preAllStb),
    .autoRefStb (autoRefStb),
    .busy       (busy)
  );

  assign refReq = owedNonZero && !busy;

  assert_one_cmd_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({preAllStb, autoRefStb}));

  // R2: a request is never raised while a sequence is running
  assert_req_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !refReq);

endmodule

// File: tb/tb_refresh_scheduler.sv
module tb_refresh_scheduler;

  localparam int NB       = 4;
  localparam int RET_US   = 16;
  localparam int ROWS     = 4;
  localparam int MHZ      = 10;
  localparam int TRAS     = 6;
  localparam int TRP      = 3;
  localparam int TRFC     = 4;
  localparam int OMAX     = 8;
  localparam int SLOT     = RET_US * MHZ / ROWS;  // 40 cycles

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NB-1:0] bankOpen = '0;
  logic          actValid = 1'b0;
  logic [1:0]    actBank = '0;
  logic          grantMan = 1'b0;
  logic          autoGrant = 1'b0;
  logic          grant;
  logic          refReq, preAllStb, autoRefStb, busy, owedOverflow;
  logic [3:0]    owedCount;

  assign grant = grantMan | (autoGrant & refReq);

  refresh_scheduler #(
    .NUM_BANKS(NB), .RETENTION_US(RET_US), .ROW_COUNT(ROWS), .CLK_MHZ(MHZ),
    .T_RAS(TRAS), .T_RP(TRP), .T_RFC(TRFC), .OWED_MAX(OMAX)
  ) dut (
    .clk(clk), .rstN(rstN), .bankOpen(bankOpen), .actValid(actValid),
    .actBank(actBank), .grant(grant), .refReq(refReq), .preAllStb(preAllStb),
    .autoRefStb(autoRefStb), .busy(busy), .owedCount(owedCount),
    .owedOverflow(owedOverflow)
  );

  always #10 clk = ~clk;  // 50 MHz

  int nChecks = 0;
  int nFail   = 0;
  int edgeN   = 0;
  int cycles  = 0;

  // scoreboard state
  int  actEdge [NB];
  int  lastPre = -1000, lastRef = -1000, busyFall = -1;
  int  preCount = 0, refCount = 0, refInPeriod = 0, lastPeriodRefs = 0;
  bit  prePend = 0, prevBusy = 0;

  task automatic chkEq(input string req, input string what, input int actV, input int expV);
    nChecks++;
    if (actV != expV) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actV, expV);
    end
  endtask

  task automatic chkGe(input string req, input string what, input int actV, input int minV);
    nChecks++;
    if (actV < minV) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected >= %0d", req, what, actV, minV);
    end
  endtask

  task automatic waitTo(input int n);
    while (edgeN < n) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
  endtask

  always @(posedge clk) begin
    if (rstN) edgeN++;
    cycles++;
    if (cycles > 5000) begin
      nFail++;
      $display("FAIL watchdog: actual %0d cycles expected <= 5000", cycles);
      summary();
      $finish;
    end
  end

  // Monitor: gap rules and idle condition on every strobe
  always @(negedge clk) begin
    if (rstN) begin
      if (preAllStb) begin
        for (int b = 0; b < NB; b++)
          if (bankOpen[b]) chkGe("R6", "tRAS before precharge-all", edgeN - actEdge[b], TRAS);
        lastPre = edgeN;
        prePend = 1;
        preCount++;
        bankOpen = '0;
      end
      if (autoRefStb) begin
        chkEq("R8", "open banks at auto-refresh", int'(bankOpen), 0);
        if (prePend) begin
          chkEq("R7", "precharge to refresh gap", edgeN - lastPre, TRP);
          prePend = 0;
        end
        if (refInPeriod > 0) chkEq("R9", "back-to-back refresh gap", edgeN - lastRef, TRFC);
        lastRef = edgeN;
        refCount++;
        refInPeriod++;
      end
      if (prevBusy && !busy) begin
        chkEq("R9", "busy fall after last refresh", edgeN - lastRef, TRFC);
        busyFall = edgeN;
        lastPeriodRefs = refInPeriod;
        refInPeriod = 0;
      end
      prevBusy = busy;
    end
  end

  initial begin
    int refBase;
    for (int b = 0; b < NB; b++) actEdge[b] = -1000;
    repeat (3) @(negedge clk);
    // R1: reset state
    chkEq("R1", "owedCount in reset", int'(owedCount), 0);
    chkEq("R1", "busy in reset", int'(busy), 0);
    chkEq("R1", "strobes in reset", int'({preAllStb, autoRefStb, refReq, owedOverflow}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chkEq("R1", "owedCount after reset", int'(owedCount), 0);
    chkEq("R1", "refReq after reset", int'(refReq), 0);

    // R4: grant with nothing owed
    waitTo(10); grantMan = 1'b1;
    waitTo(11); grantMan = 1'b0;
    waitTo(13);
    chkEq("R4", "busy after idle grant", int'(busy), 0);
    chkEq("R4", "strobes after idle grant", preCount + refCount, 0);

    // R2: first slot
    waitTo(SLOT - 1);
    chkEq("R2", "owedCount before first slot", int'(owedCount), 0);
    chkEq("R2", "refReq before first slot", int'(refReq), 0);
    waitTo(SLOT);
    chkEq("R2", "owedCount at first slot", int'(owedCount), 1);
    chkEq("R2", "refReq at first slot", int'(refReq), 1);

    // R5: all banks closed, grant sampled at edge SLOT+1
    grantMan = 1'b1;
    waitTo(SLOT + 1); grantMan = 1'b0;
    chkEq("R5", "auto-refresh in grant cycle", int'(autoRefStb), 1);
    chkEq("R5", "no precharge-all", int'(preAllStb), 0);
    chkEq("R9", "busy in grant cycle", int'(busy), 1);
    waitTo(SLOT + 2 + TRFC);
    chkEq("R5", "precharge count", preCount, 0);
    chkEq("R9", "busy fall edge", busyFall, SLOT + 1 + TRFC);
    chkEq("R11", "owedCount drained", int'(owedCount), 0);

    // R6/R7/R8: two banks opened shortly before the grant
    waitTo(2*SLOT - 5); actValid = 1'b1; actBank = 2'd1; bankOpen[1] = 1'b1; actEdge[1] = 2*SLOT - 4;
    waitTo(2*SLOT - 4); actValid = 1'b0;
    waitTo(2*SLOT - 3); actValid = 1'b1; actBank = 2'd3; bankOpen[3] = 1'b1; actEdge[3] = 2*SLOT - 2;
    waitTo(2*SLOT - 2); actValid = 1'b0;
    waitTo(2*SLOT);     grantMan = 1'b1;
    waitTo(2*SLOT + 1); grantMan = 1'b0;
    waitTo(2*SLOT + 12);
    chkEq("R6", "precharge-all edge (youngest tRAS)", lastPre, 2*SLOT - 2 + TRAS);
    chkEq("R7", "auto-refresh edge", lastRef, 2*SLOT - 2 + TRAS + TRP);
    chkEq("R9", "busy fall edge", busyFall, 2*SLOT - 2 + TRAS + TRP + TRFC);

    // R11: three owed refreshes drained back to back
    waitTo(5*SLOT - 1);
    chkEq("R2", "owedCount two slots unserved", int'(owedCount), 2);
    waitTo(5*SLOT);
    chkEq("R11", "owedCount three owed", int'(owedCount), 3);
    chkEq("R2", "refReq while owed", int'(refReq), 1);
    grantMan = 1'b1;
    waitTo(5*SLOT + 1); grantMan = 1'b0;
    waitTo(5*SLOT + 2 + 3*TRFC);
    chkEq("R11", "refreshes in busy period", lastPeriodRefs, 3);
    chkEq("R9", "last refresh edge", lastRef, 5*SLOT + 1 + 2*TRFC);
    chkEq("R9", "busy fall edge", busyFall, 5*SLOT + 1 + 3*TRFC);
    chkEq("R11", "owedCount after drain", int'(owedCount), 0);

    // R10: saturation and sticky overflow (slots 6..14 unserved)
    waitTo(13*SLOT);
    chkEq("R10", "owedCount at maximum", int'(owedCount), OMAX);
    chkEq("R10", "overflow before lost slot", int'(owedOverflow), 0);
    waitTo(14*SLOT);
    chkEq("R10", "owedCount saturated", int'(owedCount), OMAX);
    chkEq("R10", "overflow after lost slot", int'(owedOverflow), 1);
    grantMan = 1'b1;
    waitTo(14*SLOT + 1); grantMan = 1'b0;
    waitTo(14*SLOT + 2 + OMAX*TRFC);
    chkEq("R11", "refreshes after saturation", lastPeriodRefs, OMAX);
    chkEq("R9", "busy fall after drain", busyFall, 14*SLOT + 1 + OMAX*TRFC);
    chkEq("R11", "owedCount after full drain", int'(owedCount), 0);
    chkEq("R10", "overflow stays set", int'(owedOverflow), 1);

    // R3: prompt grants, one window of ROWS slots
    waitTo(15*SLOT - 1);
    autoGrant = 1'b1;
    refBase = refCount;
    waitTo(15*SLOT + ROWS*SLOT);
    chkEq("R3", "refreshes per retention window", refCount - refBase, ROWS);
    autoGrant = 1'b0;
    waitTo(15*SLOT + ROWS*SLOT + 10);
    summary();
    $finish;
  end

endmodule